// File: doc/BRIEF.md
# Cascaded Interrupt Request and Vector Logic

This block holds the request state for sixteen interrupt lines, split across two chained eight-line controllers: a primary bank (lines 0 to 7) and a secondary bank (lines 8 to 15). Devices raise and lower their lines with single-cycle pulses. The block keeps a request register, an in-service register and a per-line trigger-mode register. From these it drives a pending flag and the vector of the most urgent unmasked request. Each bank's vector base and mask come from an outside programming interface as plain inputs.

When the processor accepts an interrupt, it returns the vector it took. The block decodes that vector back to a line and marks the line in service. It drops the request if the line is edge-triggered. A level-triggered line keeps its request. A command interface can clear any in-service bit. The trigger-mode registers have one byte write port and one read-back port per bank. Bits that must stay edge-triggered are forced to zero on every write.

Top module: `cascade_irq_core`

## Requirements
- R1: A raise pulse with line number 0..15 sets request bit `line` of `irr_out`. A lower pulse clears that bit. A pulse whose 5-bit line number is 16 or more changes nothing. A lower pulse or an acknowledge clear takes precedence over a raise of the same bit in the same cycle.
- R2: A raise on line 2 sets request bits 9 and 2 together, and no other bit.
- R3: `pending` is high exactly when `irr_out & ~{mask_s, mask_m}` is nonzero.
- R4: Among the unmasked requests, the lowest line number wins, so every primary line beats every secondary line. `vec` equals `base_m + line` for lines 0..7 and `base_s + (line-8)` for lines 8..15, computed modulo 256.
- R5: An acknowledge vector `v` in `base_m..base_m+7` selects line `v[2:0]`. Otherwise, a vector in `base_s..base_s+7` selects line `8+v[2:0]`. The primary range is checked first. A vector outside both ranges changes neither `isr_out` nor `irr_out`. Range ends do not wrap.
- R6: An accepted acknowledge sets the selected bit of `isr_out`. It clears the selected request bit only if that line's trigger-mode bit is 0 (edge). If the bit is 1 (level), the request stays set.
- R7: A write to a trigger-mode register stores `wdata & 8'hF8` for the primary bank and `wdata & 8'hDE` for the secondary bank. `trig_rd_m` and `trig_rd_s` always show the stored bytes. Trigger bit `i` of the primary byte governs line `i`, and bit `i` of the secondary byte governs line `8+i`.
- R8: A clock edge with `rst_n` low clears the request, in-service and trigger-mode registers.
- R9: When no unmasked request exists, `vec_valid` is low and `vec` is 8'h00. Otherwise `vec_valid` is high.
- R10: An in-service clear pulse clears bit `isr_clr_line` of `isr_out` at the clock edge where it is sampled. It takes precedence over an acknowledge that sets the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_vld | input | 1 | Raise pulse |
| raise_line | input | 5 | Line raised (16 and above rejected) |
| lower_vld | input | 1 | Lower pulse |
| lower_line | input | 5 | Line lowered (16 and above rejected) |
| mask_m | input | 8 | Primary bank mask, 1 = masked |
| mask_s | input | 8 | Secondary bank mask, 1 = masked |
| base_m | input | 8 | Primary bank vector base |
| base_s | input | 8 | Secondary bank vector base |
| ack_vld | input | 1 | Acknowledge pulse |
| ack_vec | input | 8 | Vector being acknowledged |
| isr_clr_vld | input | 1 | In-service clear pulse |
| isr_clr_line | input | 4 | Line whose in-service bit is cleared |
| trig_wr_m | input | 1 | Write strobe, primary trigger-mode byte |
| trig_wr_s | input | 1 | Write strobe, secondary trigger-mode byte |
| trig_wdata | input | 8 | Trigger-mode write data |
| trig_rd_m | output | 8 | Stored primary trigger-mode byte |
| trig_rd_s | output | 8 | Stored secondary trigger-mode byte |
| irr_out | output | 16 | Request register, bit n = line n |
| isr_out | output | 16 | In-service register, bit n = line n |
| pending | output | 1 | Unmasked request exists |
| vec_valid | output | 1 | `vec` holds a live vector |
| vec | output | 8 | Vector of the winning request |

## Verification
Every register in this block updates on the edge that samples its pulse. The request, in-service and trigger-mode outputs therefore change one edge after a raise, lower, acknowledge, clear or write. `pending`, `vec_valid` and `vec` are combinational from the stored requests and the mask and base inputs. They follow that same edge, or the mask and base inputs directly with no edge at all. The bench drives each pulse on a falling edge and removes it on the next falling edge. It samples every result at that second falling edge, half a period after the updating edge.

// File: rtl/irqc_pkg.sv
// Shared sizing for the cascaded interrupt request logic.
// Assumes exactly two banks of eight lines each (primary, secondary).
package irqc_pkg;
    localparam int CHIP_LINES = 8;
    localparam int CHIPS      = 2;
    localparam int LINES      = CHIP_LINES * CHIPS;
    localparam int IDX_W      = $clog2(LINES);
    localparam int REQ_W      = IDX_W + 1;
    localparam int SUB_W      = $clog2(CHIP_LINES);
    localparam int BYTE_W     = 8;
endpackage

// File: rtl/irq_trig_ctl.sv
// Trigger-mode byte for one bank (1 = level, 0 = edge).
// Assumes write data is qualified by wr_en only; bits clear in WR_MASK
// are forced to edge mode on every write.
module irq_trig_ctl #(
    parameter int                W       = irqc_pkg::BYTE_W,
    parameter logic [W-1:0]      WR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Store the masked write data; reset to all-edge.
    always_ff @(posedge clk) begin : trig_store
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata & WR_MASK;
    end
endmodule

// File: rtl/irq_ack_decode.sv
// Maps an acknowledged vector back to a line by range match against each
// bank base. Primary range is tried first; ranges do not wrap past 255.
// Assumes two banks of CHIP_LINES lines.
module irq_ack_decode #(
    parameter int CHIP_LINES = irqc_pkg::CHIP_LINES,
    parameter int IDX_W      = irqc_pkg::IDX_W,
    parameter int BYTE_W     = irqc_pkg::BYTE_W
) (
    input  logic              ack_vld,
    input  logic [BYTE_W-1:0] ack_vec,
    input  logic [BYTE_W-1:0] base_m,
    input  logic [BYTE_W-1:0] base_s,
    output logic              hit,
    output logic [IDX_W-1:0]  line
);
    localparam int SUB_W = $clog2(CHIP_LINES);
    localparam int EXT_W = BYTE_W + 1;
    localparam logic [EXT_W-1:0] SPAN = EXT_W'(CHIP_LINES - 1);

    logic [EXT_W-1:0] v_x, bm_x, bs_x;
    logic             in_m, in_s;

    // Range compare in one extra bit so base+7 cannot wrap.
    always_comb begin : range_match
        v_x  = {1'b0, ack_vec};
        bm_x = {1'b0, base_m};
        bs_x = {1'b0, base_s};
        in_m = (v_x >= bm_x) && (v_x <= bm_x + SPAN);
        in_s = (v_x >= bs_x) && (v_x <= bs_x + SPAN);
        hit  = ack_vld && (in_m || in_s);
        line = {!in_m, ack_vec[SUB_W-1:0]};
    end
endmodule

// File: rtl/irq_prio_scan.sv
// Fixed-priority scan over all lines: the lowest unmasked request wins and
// its vector is the bank base plus its index inside the bank.
// Assumes lines below CHIP_LINES belong to the primary bank.
module irq_prio_scan #(
    parameter int LINES      = irqc_pkg::LINES,
    parameter int CHIP_LINES = irqc_pkg::CHIP_LINES,
    parameter int IDX_W      = irqc_pkg::IDX_W,
    parameter int BYTE_W     = irqc_pkg::BYTE_W
) (
    input  logic [LINES-1:0]  irr,
    input  logic [LINES-1:0]  mask,
    input  logic [BYTE_W-1:0] base_m,
    input  logic [BYTE_W-1:0] base_s,
    output logic              pending,
    output logic              vld,
    output logic [BYTE_W-1:0] vec
);
    localparam int SUB_W = $clog2(CHIP_LINES);

    logic [LINES-1:0] elig;
    logic [IDX_W-1:0] sel;
    logic             found;

    // Per-bank pending terms, then a descending loop so the lowest index sticks.
    always_comb begin : pick_lowest
        elig    = irr & ~mask;
        pending = (|elig[CHIP_LINES-1:0]) || (|elig[LINES-1:CHIP_LINES]);
        found   = 1'b0;
        sel     = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    // Add the owning bank's base; idle output is zero.
    always_comb begin : form_vector
        vld = found;
        if (!found)
            vec = '0;
        else if (sel[IDX_W-1])
            vec = base_s + BYTE_W'(sel[SUB_W-1:0]);
        else
            vec = base_m + BYTE_W'(sel[SUB_W-1:0]);
    end
endmodule

// File: rtl/irq_req_bank.sv
// Request and in-service registers for all lines. Raise pulses set,
// lower pulses and edge acknowledges clear (clear wins); acknowledges set
// in-service, in-service clears win over sets. A raise on CASC_LINE sets
// both CASC_LINE and REDIR_LINE. Line numbers at or above LINES are ignored.
module irq_req_bank #(
    parameter int LINES      = irqc_pkg::LINES,
    parameter int IDX_W      = irqc_pkg::IDX_W,
    parameter int REQ_W      = irqc_pkg::REQ_W,
    parameter int CASC_LINE  = 2,
    parameter int REDIR_LINE = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raise_vld,
    input  logic [REQ_W-1:0] raise_line,
    input  logic             lower_vld,
    input  logic [REQ_W-1:0] lower_line,
    input  logic             ack_hit,
    input  logic [IDX_W-1:0] ack_line,
    input  logic [LINES-1:0] trig,
    input  logic             clr_vld,
    input  logic [IDX_W-1:0] clr_line,
    output logic [LINES-1:0] irr,
    output logic [LINES-1:0] isr
);
    localparam logic [REQ_W-1:0] LIM_V  = REQ_W'(LINES);
    localparam logic [REQ_W-1:0] CASC_V = REQ_W'(CASC_LINE);

    logic [LINES-1:0] irr_set, irr_clr, isr_set, isr_clr;

    // Decode the pulses into per-line set and clear masks.
    always_comb begin : pulse_decode
        irr_set = '0;
        irr_clr = '0;
        isr_set = '0;
        isr_clr = '0;
        if (raise_vld && (raise_line < LIM_V)) begin
            irr_set[raise_line[IDX_W-1:0]] = 1'b1;
            if (raise_line == CASC_V)
                irr_set[REDIR_LINE] = 1'b1;
        end
        if (lower_vld && (lower_line < LIM_V))
            irr_clr[lower_line[IDX_W-1:0]] = 1'b1;
        if (ack_hit) begin
            isr_set[ack_line] = 1'b1;
            if (!trig[ack_line])
                irr_clr[ack_line] = 1'b1;
        end
        if (clr_vld)
            isr_clr[clr_line] = 1'b1;
    end

    // Apply set then clear to both registers.
    always_ff @(posedge clk) begin : state_update
        if (!rst_n) begin
            irr <= '0;
            isr <= '0;
        end else begin
            irr <= (irr | irr_set) & ~irr_clr;
            isr <= (isr | isr_set) & ~isr_clr;
        end
    end
endmodule

// File: rtl/cascade_irq_core.sv
// Top of the cascaded interrupt request logic: two banks of request,
// in-service and trigger-mode state, a shared priority scan and the
// acknowledge decoder. Masks and bases come from outside as levels.
module cascade_irq_core
    import irqc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] M_TRIG_MASK = 8'hF8,
    parameter logic [BYTE_W-1:0] S_TRIG_MASK = 8'hDE,
    parameter int                CASC_LINE   = 2,
    parameter int                REDIR_LINE  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raise_vld,
    input  logic [REQ_W-1:0]  raise_line,
    input  logic              lower_vld,
    input  logic [REQ_W-1:0]  lower_line,
    input  logic [BYTE_W-1:0] mask_m,
    input  logic [BYTE_W-1:0] mask_s,
    input  logic [BYTE_W-1:0] base_m,
    input  logic [BYTE_W-1:0] base_s,
    input  logic              ack_vld,
    input  logic [BYTE_W-1:0] ack_vec,
    input  logic              isr_clr_vld,
    input  logic [IDX_W-1:0]  isr_clr_line,
    input  logic              trig_wr_m,
    input  logic              trig_wr_s,
    input  logic [BYTE_W-1:0] trig_wdata,
    output logic [BYTE_W-1:0] trig_rd_m,
    output logic [BYTE_W-1:0] trig_rd_s,
    output logic [LINES-1:0]  irr_out,
    output logic [LINES-1:0]  isr_out,
    output logic              pending,
    output logic              vec_valid,
    output logic [BYTE_W-1:0] vec
);
    localparam logic [CHIPS*BYTE_W-1:0] TRIG_MASKS = {S_TRIG_MASK, M_TRIG_MASK};

    logic [CHIPS-1:0]        trig_wr;
    logic [LINES-1:0]        trig;
    logic                    ack_hit;
    logic [IDX_W-1:0]        ack_line;

    assign trig_wr   = {trig_wr_s, trig_wr_m};
    assign trig_rd_m = trig[BYTE_W-1:0];
    assign trig_rd_s = trig[LINES-1:BYTE_W];

    for (genvar g = 0; g < CHIPS; g++) begin : g_trig
        irq_trig_ctl #(
            .W       (BYTE_W),
            .WR_MASK (TRIG_MASKS[g*BYTE_W +: BYTE_W])
        ) u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (trig_wr[g]),
            .wdata (trig_wdata),
            .q     (trig[g*BYTE_W +: BYTE_W])
        );
    end

    irq_ack_decode #(
        .CHIP_LINES (CHIP_LINES),
        .IDX_W      (IDX_W),
        .BYTE_W     (BYTE_W)
    ) u_dec (
        .ack_vld (ack_vld),
        .ack_vec (ack_vec),
        .base_m  (base_m),
        .base_s  (base_s),
        .hit     (ack_hit),
        .line    (ack_line)
    );

    irq_req_bank #(
        .LINES      (LINES),
        .IDX_W      (IDX_W),
        .REQ_W      (REQ_W),
        .CASC_LINE  (CASC_LINE),
        .REDIR_LINE (REDIR_LINE)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_vld  (raise_vld),
        .raise_line (raise_line),
        .lower_vld  (lower_vld),
        .lower_line (lower_line),
        .ack_hit    (ack_hit),
        .ack_line   (ack_line),
        .trig       (trig),
        .clr_vld    (isr_clr_vld),
        .clr_line   (isr_clr_line),
        .irr        (irr_out),
        .isr        (isr_out)
    );

    irq_prio_scan #(
        .LINES      (LINES),
        .CHIP_LINES (CHIP_LINES),
        .IDX_W      (IDX_W),
        .BYTE_W     (BYTE_W)
    ) u_scan (
        .irr     (irr_out),
        .mask    ({mask_s, mask_m}),
        .base_m  (base_m),
        .base_s  (base_s),
        .pending (pending),
        .vld     (vec_valid),
        .vec     (vec)
    );
endmodule

// File: rtl/cascade_irq_core_chk.sv
// Property checker for cascade_irq_core, attached by bind below.
// Observes ports only; assumes the default parameter values.
module cascade_irq_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        raise_vld,
    input logic [4:0]  raise_line,
    input logic        lower_vld,
    input logic [7:0]  mask_m,
    input logic [7:0]  mask_s,
    input logic [7:0]  base_m,
    input logic [7:0]  base_s,
    input logic        ack_vld,
    input logic [7:0]  ack_vec,
    input logic        isr_clr_vld,
    input logic [3:0]  isr_clr_line,
    input logic [7:0]  trig_rd_m,
    input logic [7:0]  trig_rd_s,
    input logic [15:0] irr_out,
    input logic [15:0] isr_out,
    input logic        pending,
    input logic        vec_valid,
    input logic [7:0]  vec
);
    logic [8:0] v_x, bm_x, bs_x;
    logic       ack_out_of_range;

    always_comb begin : range_view
        v_x  = {1'b0, ack_vec};
        bm_x = {1'b0, base_m};
        bs_x = {1'b0, base_s};
        ack_out_of_range = !((v_x >= bm_x) && (v_x <= bm_x + 9'd7)) &&
                           !((v_x >= bs_x) && (v_x <= bs_x + 9'd7));
    end

    // R1
    raise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld && raise_line < 5'd16 && raise_line != 5'd2 && !lower_vld && !ack_vld)
        |=> irr_out[$past(raise_line[3:0])]);

    // R3
    pending_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending == ((irr_out & ~{mask_s, mask_m}) != 16'h0));

    // R5
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_out_of_range && !isr_clr_vld) |=> $stable(isr_out));

    // R7
    trig_forced_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_rd_m & ~8'hF8) == 8'h00) && ((trig_rd_s & ~8'hDE) == 8'h00));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (irr_out == 16'h0) && (isr_out == 16'h0) &&
                   (trig_rd_m == 8'h00) && (trig_rd_s == 8'h00));

    // R9
    idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid == pending) && (!vec_valid -> vec == 8'h00));

    // R10
    isr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_clr_vld |=> !isr_out[$past(isr_clr_line)]);
endmodule

bind cascade_irq_core cascade_irq_core_chk u_chk (.*);

// File: tb/sim_cascade_irq_core.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_cascade_irq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raise_vld = 1'b0;
    logic [4:0]  raise_line = '0;
    logic        lower_vld = 1'b0;
    logic [4:0]  lower_line = '0;
    logic [7:0]  mask_m = '0, mask_s = '0;
    logic [7:0]  base_m = 8'h08, base_s = 8'h70;
    logic        ack_vld = 1'b0;
    logic [7:0]  ack_vec = '0;
    logic        isr_clr_vld = 1'b0;
    logic [3:0]  isr_clr_line = '0;
    logic        trig_wr_m = 1'b0, trig_wr_s = 1'b0;
    logic [7:0]  trig_wdata = '0;
    logic [7:0]  trig_rd_m, trig_rd_s;
    logic [15:0] irr_out, isr_out;
    logic        pending, vec_valid;
    logic [7:0]  vec;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cascade_irq_core u0 (.*);

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_raise(input logic [4:0] l);
        @(negedge clk); raise_vld = 1'b1; raise_line = l;
        @(negedge clk); raise_vld = 1'b0;
    endtask

    task automatic do_lower(input logic [4:0] l);
        @(negedge clk); lower_vld = 1'b1; lower_line = l;
        @(negedge clk); lower_vld = 1'b0;
    endtask

    task automatic do_ack(input logic [7:0] v);
        @(negedge clk); ack_vld = 1'b1; ack_vec = v;
        @(negedge clk); ack_vld = 1'b0;
    endtask

    task automatic do_clr(input logic [3:0] l);
        @(negedge clk); isr_clr_vld = 1'b1; isr_clr_line = l;
        @(negedge clk); isr_clr_vld = 1'b0;
    endtask

    task automatic do_trig(input logic sec, input logic [7:0] d);
        @(negedge clk); trig_wdata = d; trig_wr_m = !sec; trig_wr_s = sec;
        @(negedge clk); trig_wr_m = 1'b0; trig_wr_s = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 irr after reset", irr_out, 16'h0);
        chk("R8 isr after reset", isr_out, 16'h0);
        chk("R8 trig after reset", {trig_rd_s, trig_rd_m}, 16'h0);
        chk("R9 idle valid", {15'h0, vec_valid}, 16'h0);
        chk("R9 idle vector", {8'h0, vec}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_priority;
        do_raise(5'd5);
        chk("R1 raise line 5", irr_out, 16'h0020);
        chk("R4 vector line 5", {8'h0, vec}, 16'h000D);
        do_raise(5'd12);
        chk("R1 raise line 12", irr_out, 16'h1020);
        chk("R4 primary beats secondary", {8'h0, vec}, 16'h000D);
        do_lower(5'd5);
        chk("R1 lower line 5", irr_out, 16'h1000);
        chk("R4 secondary vector", {8'h0, vec}, 16'h0074);
    endtask

    task automatic t_mask;
        @(negedge clk); mask_s = 8'h10;
        @(negedge clk);
        chk("R3 masked pending", {15'h0, pending}, 16'h0);
        chk("R9 masked vector", {7'h0, vec_valid, vec}, 16'h0);
        chk("R3 request kept", irr_out, 16'h1000);
        mask_s = 8'h00;
        @(negedge clk);
        chk("R3 unmasked pending", {15'h0, pending}, 16'h1);
        do_lower(5'd12);
        chk("R1 lower line 12", irr_out, 16'h0);
    endtask

    task automatic t_cascade;
        do_raise(5'd2);
        chk("R2 line 2 sets 2 and 9", irr_out, 16'h0204);
        chk("R2 vector line 2", {8'h0, vec}, 16'h000A);
        do_lower(5'd2);
        chk("R2 lower 2 leaves 9", irr_out, 16'h0200);
        chk("R4 vector line 9", {8'h0, vec}, 16'h0071);
        do_lower(5'd9);
    endtask

    task automatic t_reject;
        do_raise(5'd16);
        chk("R1 line 16 ignored", irr_out, 16'h0);
        do_raise(5'd31);
        chk("R1 line 31 ignored", irr_out, 16'h0);
    endtask

    task automatic t_trig;
        do_trig(1'b0, 8'hFF);
        chk("R7 primary write mask", {8'h0, trig_rd_m}, 16'h00F8);
        do_trig(1'b1, 8'hFF);
        chk("R7 secondary write mask", {8'h0, trig_rd_s}, 16'h00DE);
        do_trig(1'b0, 8'h00);
        do_trig(1'b1, 8'h00);
        chk("R7 cleared", {trig_rd_s, trig_rd_m}, 16'h0);
    endtask

    task automatic t_ack_edge;
        do_raise(5'd4);
        do_ack(8'h0C);
        chk("R6 edge in-service", isr_out, 16'h0010);
        chk("R6 edge request cleared", irr_out, 16'h0);
        chk("R3 nothing pending", {15'h0, pending}, 16'h0);
    endtask

    task automatic t_isr_clr;
        do_clr(4'd4);
        chk("R10 in-service cleared", isr_out, 16'h0);
    endtask

    task automatic t_ack_level;
        do_trig(1'b0, 8'h10);
        do_raise(5'd4);
        do_ack(8'h0C);
        chk("R6 level in-service", isr_out, 16'h0010);
        chk("R6 level request kept", irr_out, 16'h0010);
        do_trig(1'b1, 8'h02);
        do_raise(5'd9);
        do_ack(8'h71);
        chk("R5 secondary decode", isr_out, 16'h0210);
        chk("R6 secondary level kept", irr_out, 16'h0210);
    endtask

    task automatic t_bad_ack;
        do_ack(8'h40);
        chk("R5 stray vector isr", isr_out, 16'h0210);
        chk("R5 stray vector irr", irr_out, 16'h0210);
        chk("R4 vector after stray", {8'h0, vec}, 16'h000C);
    endtask

    initial begin : watchdog
        #4_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_priority();
        t_mask();
        t_cascade();
        t_reject();
        t_trig();
        t_ack_edge();
        t_isr_clr();
        t_ack_level();
        t_bad_ack();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule